// File: doc/BRIEF.md
# Windowed Address-Translating Bus Bridge

This block joins a processor bus with 16-bit addresses to a shared common bus whose addresses are 20 bits wide, a 1 MB space. The top four address bits choose one of sixteen map entries. Software loads each entry with an 8-bit system page number and a valid bit. When the bridge is enabled and the chosen entry is valid, the bridge claims the access. It places `{page, offset[11:0]}` on the common bus and holds the request there until the far side acknowledges. Accesses it does not claim produce no activity at all, so local memory on the processor bus can answer them.

Write data leaves with a parity bit computed on the processor side. Read data comes back with its stored parity bit, and the bridge checks it on the processor side. A mismatch ends the access with an error and sets a flag that stays set until software clears it. When the far bus gives no acknowledge, the access ends with an error after a fixed number of cycles. A power-fail level from the far side is resynchronised and passed to the processor side as an interrupt request. Software can switch the bridge off entirely, which isolates a faulty path.

Top module: `bus_window_bridge`

## Requirements
- R1: After reset the bridge is disabled, every map entry reads 0 (invalid), and `s_req`, `p_ack`, `p_err`, `par_err_flag` and `p_pfail_irq` are 0.
- R2: `p_hit` is 1 exactly when the bridge is enabled and the map entry picked by `p_addr[15:12]` is valid. An access with `p_hit` low raises neither `s_req` nor `p_ack` for as long as `p_req` is held.
- R3: A claimed access drives `s_addr = {entry page[7:0], p_addr[11:0]}`, with `s_req` high from the cycle after `p_req` is accepted.
- R4: On a claimed write, `s_we` = 1, `s_wdata` = `p_wdata`, and `s_wpar` is the XOR of all 16 bits of `p_wdata`.
- R5: One cycle after `s_ack`, `p_ack` pulses high for exactly one cycle. On a read whose `s_rpar` equals the XOR of `s_rdata`, `p_err` = 0 and `p_rdata` = `s_rdata`.
- R6: A read whose `s_rpar` differs from the XOR of `s_rdata` completes with `p_err` = 1 and sets `par_err_flag`. The flag stays set until a configuration write to address 16 with bit 1 set.
- R7: While the enable bit is 0, `s_req` never rises, whatever the map holds.
- R8: If `s_ack` has not arrived after `s_req` has been high for 64 cycles, `s_req` drops and `p_ack` pulses with `p_err` = 1. The parity flag is left unchanged.
- R9: `p_pfail_irq` follows `s_pfail` two clock edges later.
- R10: While `s_req` is high and unacknowledged, `s_req`, `s_addr`, `s_we` and `s_wdata` hold steady.
- R11: The configuration port works as follows. Addresses 0 to 15 write and read entry n as `{valid (bit 8), page (bits 7:0)}`. Address 16 writes the enable in bit 0 and reads `{par_err_flag (bit 1), enable (bit 0)}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address: 0-15 map entries, 16 control |
| cfg_wdata | input | 9 | Configuration write data |
| cfg_rdata | output | 9 | Configuration read data for `cfg_addr` |
| p_req | input | 1 | Processor access request, held until `p_ack` |
| p_we | input | 1 | Processor write (1) or read (0) |
| p_addr | input | 16 | Processor address |
| p_wdata | input | 16 | Processor write data |
| p_hit | output | 1 | Bridge claims the current address |
| p_ack | output | 1 | One-cycle completion pulse |
| p_err | output | 1 | Completion carries an error (parity or timeout) |
| p_rdata | output | 16 | Read data |
| p_pfail_irq | output | 1 | Power-fail interrupt request to the processor side |
| par_err_flag | output | 1 | Sticky read-parity error flag |
| s_req | output | 1 | Common-bus request |
| s_we | output | 1 | Common-bus write |
| s_addr | output | 20 | Common-bus system address |
| s_wdata | output | 16 | Common-bus write data |
| s_wpar | output | 1 | Write parity bit stored with the data |
| s_rdata | input | 16 | Common-bus read data |
| s_rpar | input | 1 | Stored parity bit returned with read data |
| s_ack | input | 1 | Common-bus acknowledge |
| s_pfail | input | 1 | Far-side power-fail level |

## Verification
The timeout is the hardest case to reach. It needs a far side that never answers, and then 64 cycles of unchanged request without any other traffic getting in the way. The bench's far-side model has a silent mode that watches `s_req` and counts its high cycles until the error completion appears. Parity failures and unclaimed addresses are reached by random stimulus with a fixed seed: the far-side model corrupts about one read in eight, and the map is reloaded with about half its entries invalid at intervals. Directed cases cover the top page and offset, disabling the bridge, clearing the flag, and the power-fail path.

// File: rtl/bus_window_bridge.sv
module bus_window_bridge #(
  parameter int PAW     = 16,
  parameter int SAW     = 20,
  parameter int DW      = 16,
  parameter int IDXW    = 4,
  parameter int TIMEOUT = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IDXW:0]         cfg_addr,
  input  logic [SAW-PAW+IDXW:0] cfg_wdata,
  output logic [SAW-PAW+IDXW:0] cfg_rdata,
  input  logic                  p_req,
  input  logic                  p_we,
  input  logic [PAW-1:0]        p_addr,
  input  logic [DW-1:0]         p_wdata,
  output logic                  p_hit,
  output logic                  p_ack,
  output logic                  p_err,
  output logic [DW-1:0]         p_rdata,
  output logic                  p_pfail_irq,
  output logic                  par_err_flag,
  output logic                  s_req,
  output logic                  s_we,
  output logic [SAW-1:0]        s_addr,
  output logic [DW-1:0]         s_wdata,
  output logic                  s_wpar,
  input  logic [DW-1:0]         s_rdata,
  input  logic                  s_rpar,
  input  logic                  s_ack,
  input  logic                  s_pfail
);
  localparam int OFFW    = PAW - IDXW;
  localparam int PGW     = SAW - OFFW;
  localparam int ENTRIES = 1 << IDXW;
  localparam int TCW     = $clog2(TIMEOUT) + 1;

  typedef enum logic [1:0] {IDLE, BUSY, DONE} st_t;

  st_t              st_q;
  logic [PGW-1:0]   page_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic             en_q;
  logic [TCW-1:0]   tcnt_q;
  logic [1:0]       pf_sync_q;

  wire [IDXW-1:0] idx      = p_addr[PAW-1:OFFW];
  wire            ctl_sel  = cfg_addr[IDXW];
  wire            ctl_wr   = cfg_we && ctl_sel;
  wire            map_wr   = cfg_we && !ctl_sel;
  wire            accept   = (st_q == IDLE) && p_req && p_hit;
  wire            rd_bad   = !s_we && ((^s_rdata) != s_rpar);
  wire            expired  = (tcnt_q == TCW'(TIMEOUT - 1));

  assign p_hit       = en_q && vld_q[idx];
  assign s_req       = (st_q == BUSY);
  assign p_pfail_irq = pf_sync_q[1];
  assign cfg_rdata   = ctl_sel ? {{(PGW-1){1'b0}}, par_err_flag, en_q}
                               : {vld_q[cfg_addr[IDXW-1:0]], page_q[cfg_addr[IDXW-1:0]]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) page_q[i] <= '0;
    end else if (map_wr) begin
      vld_q[cfg_addr[IDXW-1:0]]  <= cfg_wdata[PGW];
      page_q[cfg_addr[IDXW-1:0]] <= cfg_wdata[PGW-1:0];
    end else if (ctl_wr) begin
      en_q <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pf_sync_q <= '0;
    else        pf_sync_q <= {pf_sync_q[0], s_pfail};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= IDLE;
      tcnt_q       <= '0;
      p_ack        <= 1'b0;
      p_err        <= 1'b0;
      p_rdata      <= '0;
      par_err_flag <= 1'b0;
      s_we         <= 1'b0;
      s_addr       <= '0;
      s_wdata      <= '0;
      s_wpar       <= 1'b0;
    end else begin
      if (ctl_wr && cfg_wdata[1]) par_err_flag <= 1'b0;
      case (st_q)
        IDLE: if (accept) begin
          st_q    <= BUSY;
          tcnt_q  <= '0;
          s_we    <= p_we;
          s_addr  <= {page_q[idx], p_addr[OFFW-1:0]};
          s_wdata <= p_wdata;
          s_wpar  <= ^p_wdata;
        end
        BUSY: if (s_ack) begin
          st_q    <= DONE;
          p_ack   <= 1'b1;
          p_err   <= rd_bad;
          p_rdata <= s_rdata;
          if (rd_bad) par_err_flag <= 1'b1;
        end else if (expired) begin
          st_q  <= DONE;
          p_ack <= 1'b1;
          p_err <= 1'b1;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
        default: begin
          st_q  <= IDLE;
          p_ack <= 1'b0;
          p_err <= 1'b0;
        end
      endcase
    end
  end

  logic [TCW-1:0] req_age_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !s_req) req_age_q <= '0;
    else                  req_age_q <= req_age_q + 1'b1;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && !s_ack && !expired |=> s_req && $stable(s_addr) && $stable(s_we) && $stable(s_wdata));
  // R7
  no_fwd_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == IDLE) && !en_q |=> !s_req);
  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_ack |=> !p_ack);
  // R8
  err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_err |-> p_ack);
  // R8
  req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req |-> req_age_q < TCW'(TIMEOUT));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_flag && !(ctl_wr && cfg_wdata[1]) |=> par_err_flag);
  // R9
  pfail_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_pfail_irq) |-> $past(s_pfail, 2));
endmodule

// File: tb/tb_bus_window_bridge.sv
module tb_bus_window_bridge;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [4:0] cfg_addr = 0; logic [8:0] cfg_wdata = 0; logic [8:0] cfg_rdata;
  logic p_req = 0, p_we = 0; logic [15:0] p_addr = 0, p_wdata = 0;
  logic p_hit, p_ack, p_err, p_pfail_irq, par_err_flag;
  logic [15:0] p_rdata;
  logic s_req, s_we, s_wpar; logic [19:0] s_addr; logic [15:0] s_wdata;
  logic [15:0] s_rdata = 0; logic s_rpar = 0, s_ack = 0, s_pfail = 0;

  int checks = 0, fails = 0;
  logic [7:0] m_page [16];
  logic       m_vld  [16];
  logic       m_en = 0, m_flag = 0;

  always #4 clk = ~clk;

  bus_window_bridge dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [8:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 16) begin m_vld[a] = d[8]; m_page[a] = d[7:0]; end
    else begin m_en = d[0]; if (d[1]) m_flag = 0; end
    #1 check(cfg_rdata == (a < 16 ? d : {7'd0, m_flag, m_en}), "R11", cfg_rdata, d);
  endtask

  function automatic logic exp_hit(input logic [15:0] a);
    return m_en && m_vld[a[15:12]];
  endfunction

  // mode 0 normal, 1 silent far side
  task automatic access(input logic we, input logic [15:0] a, input logic [15:0] wd,
                        input int dly, input logic bad, input int mode);
    logic [15:0] rd;
    logic hit;
    hit = exp_hit(a);
    p_req = 1; p_we = we; p_addr = a; p_wdata = wd;
    #1 check(p_hit == hit, "R2", p_hit, hit);
    @(negedge clk);
    if (!hit) begin
      for (int i = 0; i < 6; i++) begin
        check(!s_req && !p_ack, m_en ? "R2" : "R7", {s_req, p_ack}, 0);
        @(negedge clk);
      end
      p_req = 0;
      return;
    end
    check(s_req == 1, "R3", s_req, 1);
    check(s_addr == {m_page[a[15:12]], a[11:0]}, "R3", s_addr, {m_page[a[15:12]], a[11:0]});
    check(s_we == we, "R4", s_we, we);
    if (we) begin
      check(s_wdata == wd, "R4", s_wdata, wd);
      check(s_wpar == ^wd, "R4", s_wpar, ^wd);
    end
    if (mode == 1) begin
      int n = 0;
      while (!p_ack && n < 200) begin
        if (s_req) n++;
        @(negedge clk);
      end
      check(n == 64, "R8", n, 64);
      check(p_ack && p_err && !s_req, "R8", {p_ack, p_err, s_req}, 3'b110);
      check(par_err_flag == m_flag, "R8", par_err_flag, m_flag);
      p_req = 0;
      @(negedge clk);
      return;
    end
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check(s_req && !p_ack && s_addr == {m_page[a[15:12]], a[11:0]}, "R10", {s_req, p_ack}, 2'b10);
    end
    rd = 16'($urandom);
    s_ack = 1; s_rdata = rd; s_rpar = (^rd) ^ bad;
    @(negedge clk);
    s_ack = 0;
    if (!we && bad) m_flag = 1;
    check(p_ack == 1, "R5", p_ack, 1);
    check(p_err == (!we && bad), (!we && bad) ? "R6" : "R5", p_err, !we && bad);
    if (!we && !bad) check(p_rdata == rd, "R5", p_rdata, rd);
    check(par_err_flag == m_flag, "R6", par_err_flag, m_flag);
    p_req = 0;
    @(negedge clk);
    check(!p_ack && !s_req, "R5", {p_ack, s_req}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 16; i++) begin m_page[i] = 0; m_vld[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check(!s_req && !p_ack && !p_err && !par_err_flag && !p_pfail_irq, "R1",
          {s_req, p_ack, p_err, par_err_flag, p_pfail_irq}, 0);
    for (int i = 0; i < 17; i++) begin
      cfg_addr = 5'(i); #1 check(cfg_rdata == 0, "R1", cfg_rdata, 0);
    end
    @(negedge clk);
    // R7 disabled: valid map yet no forwarding
    cfg_write(5'd3, 9'h1AB);
    access(1'b0, 16'h3123, 16'h0, 0, 1'b0, 0);
    cfg_write(5'd16, 9'h001);
    // R3 boundary: top page, top offset
    cfg_write(5'd15, 9'h1FF);
    access(1'b1, 16'hFFFF, 16'h8001, 1, 1'b0, 0);
    access(1'b0, 16'hF000, 16'h0, 0, 1'b0, 0);
    // R6 parity fail then sticky, then clear
    access(1'b0, 16'h3456, 16'h0, 2, 1'b1, 0);
    access(1'b0, 16'h3457, 16'h0, 0, 1'b0, 0);
    check(par_err_flag == 1, "R6", par_err_flag, 1);
    cfg_write(5'd16, 9'h003);
    check(par_err_flag == 0, "R6", par_err_flag, 0);
    // R8 timeout
    access(1'b0, 16'h3000, 16'h0, 0, 1'b0, 1);
    // R9 power-fail path
    s_pfail = 1;
    @(negedge clk); check(p_pfail_irq == 0, "R9", p_pfail_irq, 0);
    @(negedge clk); check(p_pfail_irq == 1, "R9", p_pfail_irq, 1);
    s_pfail = 0;
    @(negedge clk); check(p_pfail_irq == 1, "R9", p_pfail_irq, 1);
    @(negedge clk); check(p_pfail_irq == 0, "R9", p_pfail_irq, 0);
    // random traffic
    for (int k = 0; k < 300; k++) begin
      if (k % 25 == 0)
        for (int e = 0; e < 16; e++) cfg_write(5'(e), {1'($urandom), 8'($urandom)});
      if (k % 60 == 59) cfg_write(5'd16, 9'h002);
      if (k % 60 == 0 && k > 0) cfg_write(5'd16, 9'h001);
      access(1'($urandom), 16'($urandom), 16'($urandom), int'($urandom % 6),
             ($urandom % 8) == 0, 0);
    end
    summary();
  end
endmodule